// File: doc/BRIEF.md
# DDR2 Read Command Timing Checker

This block sits beside a DDR2 command bus and checks, clock by clock, the command spacing around READ bursts. On each clock it takes one decoded command with its bank address and the A10 bit. It also takes static timing settings: additive latency, CAS latency, burst length of 4 or 8, and the read-to-precharge time in clocks. It flags READ commands that cut into a running burst in a way the protocol forbids. It also flags PRECHARGE commands that come too early, hit a bank that is closing itself through auto precharge, or land in the gap of a read interrupt. WRITE commands that follow a READ too closely are flagged as well.

A violation shows as a one-clock pulse on `viol_o`, together with a reason code. Both appear on the clock after the offending command. The settings are meant to change only while reset is held. The block observes the bus and never drives it.

Top module: `ddr2_rd_timing_chk`

## Requirements
- R1: After reset no violation is reported, and no bank has a pending read, so a PRECHARGE to any bank is legal.
- R2: `cmd_i` encodes 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, and 5 to 7 as deselect. A violation raises `viol_o` for one clock on the clock after the command, with `reason_o` as follows: 1 bad interrupt spacing, 2 interrupt not allowed, 3 precharge in interrupt gap, 4 precharge too early, 5 precharge after auto-precharge read, 6 read-to-write too close. Otherwise `reason_o` is 0. NOP, deselect and ACTIVATE never raise a violation.
- R3: A READ issued d clocks after the previous READ, with d below BL/2 and d not equal to 2, gives reason 1. A READ at d of BL/2 or more is legal.
- R4: With BL=8, a READ at exactly d=2 after a READ that had A10 low is a legal interrupt. The second READ may go to any bank and may set A10 either way.
- R5: With BL=8, a READ at d=2 after a READ that had A10 high gives reason 2.
- R6: With BL=8 and the first READ's A10 low, a PRECHARGE at d=1 that covers that READ's bank gives reason 3. A READ at d=2 to a bank covered by that PRECHARGE also gives reason 3.
- R7: With BL=4, a PRECHARGE to a bank whose last READ had A10 low gives reason 4 if it comes fewer than max(AL+2, AL+tRTP) clocks after that READ.
- R8: With BL=8, the same bound is max(AL+4, AL+2+tRTP) clocks.
- R9: A PRECHARGE to a bank whose last READ had A10 high, with no ACTIVATE or PRECHARGE to that bank since, gives reason 5.
- R10: A PRECHARGE with A10 high covers all banks, and each bank is checked as in R6 to R9.
- R11: A WRITE issued fewer than RL-WL+BL/2+1 clocks (that is, BL/2+2) after the last READ gives reason 6. Here RL=AL+CL and WL=RL-1.
- R12: When several reasons apply to one command, the lowest code is reported.
- R13: An ACTIVATE or PRECHARGE to a bank clears its pending read, so a later PRECHARGE to that bank is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | BANK_W (3) | Bank address |
| a10_i | input | 1 | A10: auto precharge on READ, all banks on PRECHARGE |
| al_i | input | LAT_W (4) | Additive latency in clocks |
| cl_i | input | LAT_W (4) | CAS latency in clocks |
| bl8_i | input | 1 | 1 selects burst length 8, 0 selects 4 |
| trtp_i | input | LAT_W (4) | Read-to-precharge time in clocks |
| viol_o | output | 1 | One-clock violation pulse |
| reason_o | output | 3 | Reason code of the violation, 0 when none |

## Verification
Directed READ pairs at spacings 1, 2, 3 and BL/2 tell a legal interrupt apart from bad spacing and from an interrupt that auto precharge forbids. PRECHARGE is placed one clock either side of the bound under three settings: BL=8 where tRTP dominates, BL=8 where AL+BL/2 dominates, and BL=4 with nonzero AL. These placements show which of the two limits is in force. Single-bank and all-bank PRECHARGE after an auto-precharge read, and WRITE at the edge of the read-to-write gap, cover the remaining reasons. Seeded random command streams on a few colliding banks then mix every reason against a reference model that works on clock stamps.

// File: rtl/ddr2_chk_pkg.sv
package ddr2_chk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    RSN_NONE      = 3'd0,
    RSN_SPACING   = 3'd1,
    RSN_NO_INTR   = 3'd2,
    RSN_PRE_WIN   = 3'd3,
    RSN_PRE_EARLY = 3'd4,
    RSN_PRE_AP    = 3'd5,
    RSN_RD2WR     = 3'd6
  } reason_e;

  localparam int NUM_REASONS = 6;
endpackage

// File: rtl/bank_tracker.sv
module bank_tracker #(
  parameter int AGE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_hit_i,
  input  logic             act_hit_i,
  input  logic             pre_hit_i,
  input  logic             a10_i,
  input  logic [AGE_W-1:0] min_gap_i,
  output logic             early_o,
  output logic             ap_viol_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic             valid_q, ap_q;
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ap_q    <= 1'b0;
      age_q   <= '0;
    end else if (rd_hit_i) begin
      valid_q <= 1'b1;
      ap_q    <= a10_i;
      age_q   <= AGE_W'(1);
    end else begin
      if (act_hit_i || pre_hit_i) valid_q <= 1'b0;
      if (age_q != AGE_MAX) age_q <= age_q + AGE_W'(1);
    end
  end

  assign early_o   = pre_hit_i && valid_q && !ap_q && (age_q < min_gap_i);
  assign ap_viol_o = pre_hit_i && valid_q && ap_q;

  // a bank reopened by ACTIVATE carries no pending read into a PRECHARGE
  p_act_clears_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(act_hit_i) && pre_hit_i) |-> (!early_o && !ap_viol_o));
endmodule

// File: rtl/burst_tracker.sv
module burst_tracker #(
  parameter int NUM_BANKS = 8,
  parameter int AGE_W     = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 is_rd_i,
  input  logic                 is_wr_i,
  input  logic [NUM_BANKS-1:0] bank_dec_i,
  input  logic [NUM_BANKS-1:0] pre_mask_i,
  input  logic                 a10_i,
  input  logic                 bl8_i,
  input  logic [AGE_W-1:0]     half_i,
  input  logic [AGE_W-1:0]     rw_gap_i,
  output logic                 spacing_o,
  output logic                 no_intr_o,
  output logic                 pre_win_o,
  output logic                 rd2wr_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic                 valid_q, ap_q;
  logic [AGE_W-1:0]     age_q;
  logic [NUM_BANKS-1:0] rd_bank_q, win_mask_q, win_mask_d;
  logic                 win_open, in_burst, at_two;

  assign win_open = valid_q && bl8_i && !ap_q && (age_q == AGE_W'(1));
  assign in_burst = valid_q && (age_q < half_i);
  assign at_two   = (age_q == AGE_W'(2));

  assign spacing_o = is_rd_i && in_burst && !at_two;
  assign no_intr_o = is_rd_i && in_burst && at_two && ap_q;
  assign pre_win_o = (win_open && |(pre_mask_i & rd_bank_q)) ||
                     (is_rd_i && in_burst && at_two && !ap_q && |(win_mask_q & bank_dec_i));
  assign rd2wr_o   = is_wr_i && valid_q && (age_q < rw_gap_i);
  assign win_mask_d = win_open ? pre_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      ap_q       <= 1'b0;
      age_q      <= '0;
      rd_bank_q  <= '0;
      win_mask_q <= '0;
    end else begin
      win_mask_q <= win_mask_d;
      if (is_rd_i) begin
        valid_q   <= 1'b1;
        ap_q      <= a10_i;
        age_q     <= AGE_W'(1);
        rd_bank_q <= bank_dec_i;
      end else if (age_q != AGE_MAX) begin
        age_q <= age_q + AGE_W'(1);
      end
    end
  end

  // the interrupt gap is a single clock, so its record lives one clock
  p_win_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_mask_q != '0) |=> (win_mask_q == '0));
endmodule

// File: rtl/viol_encoder.sv
module viol_encoder
  import ddr2_chk_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_REASONS-1:0] flags_i,
  output logic                   viol_o,
  output logic [2:0]             reason_o
);
  logic [2:0] code_d;

  // lowest code wins
  always_comb begin
    code_d = RSN_NONE;
    for (int i = NUM_REASONS - 1; i >= 0; i--) begin
      if (flags_i[i]) code_d = 3'(i + 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o   <= 1'b0;
      reason_o <= RSN_NONE;
    end else begin
      viol_o   <= |flags_i;
      reason_o <= code_d;
    end
  end

  p_code_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (reason_o != 3'd0 && reason_o <= 3'(NUM_REASONS)));
endmodule

// File: rtl/ddr2_rd_timing_chk.sv
module ddr2_rd_timing_chk
  import ddr2_chk_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int LAT_W     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              a10_i,
  input  logic [LAT_W-1:0]  al_i,
  input  logic [LAT_W-1:0]  cl_i,
  input  logic              bl8_i,
  input  logic [LAT_W-1:0]  trtp_i,
  output logic              viol_o,
  output logic [2:0]        reason_o
);
  // sums of up to three latency fields plus a few clocks
  localparam int AGE_W = LAT_W + 2;

  logic is_rd, is_wr, is_pre, is_act;
  logic [NUM_BANKS-1:0] bank_dec, pre_mask, early_v, apv_v;
  logic [AGE_W-1:0] al_w, half_w, gap_burst, gap_rtp, pre_gap, rl_w, wl_w, rw_gap;
  logic spacing, no_intr, pre_win, rd2wr;
  logic [NUM_REASONS-1:0] flags;

  assign is_rd  = (cmd_i == CMD_RD);
  assign is_wr  = (cmd_i == CMD_WR);
  assign is_pre = (cmd_i == CMD_PRE);
  assign is_act = (cmd_i == CMD_ACT);

  assign bank_dec = NUM_BANKS'(1) << bank_i;
  assign pre_mask = !is_pre ? '0 : (a10_i ? '1 : bank_dec);

  assign al_w      = AGE_W'(al_i);
  assign half_w    = bl8_i ? AGE_W'(4) : AGE_W'(2);
  assign gap_burst = al_w + half_w;
  // tRTP counts from the last 4-bit prefetch
  assign gap_rtp   = al_w + AGE_W'(trtp_i) + (bl8_i ? AGE_W'(2) : AGE_W'(0));
  assign pre_gap   = (gap_rtp > gap_burst) ? gap_rtp : gap_burst;
  assign rl_w      = al_w + AGE_W'(cl_i);
  assign wl_w      = rl_w - AGE_W'(1);
  assign rw_gap    = rl_w - wl_w + half_w + AGE_W'(1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_tracker #(.AGE_W(AGE_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_hit_i (is_rd && bank_dec[b]),
      .act_hit_i(is_act && bank_dec[b]),
      .pre_hit_i(pre_mask[b]),
      .a10_i    (a10_i),
      .min_gap_i(pre_gap),
      .early_o  (early_v[b]),
      .ap_viol_o(apv_v[b])
    );
  end

  burst_tracker #(.NUM_BANKS(NUM_BANKS), .AGE_W(AGE_W)) u_burst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .is_rd_i   (is_rd),
    .is_wr_i   (is_wr),
    .bank_dec_i(bank_dec),
    .pre_mask_i(pre_mask),
    .a10_i     (a10_i),
    .bl8_i     (bl8_i),
    .half_i    (half_w),
    .rw_gap_i  (rw_gap),
    .spacing_o (spacing),
    .no_intr_o (no_intr),
    .pre_win_o (pre_win),
    .rd2wr_o   (rd2wr)
  );

  assign flags = {rd2wr, |apv_v, |early_v, pre_win, no_intr, spacing};

  viol_encoder u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flags),
    .viol_o  (viol_o),
    .reason_o(reason_o)
  );

  p_quiet_cmds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_NOP || cmd_i == CMD_ACT || cmd_i > 3'd4) |=> !viol_o);

  p_rd_rd_adjacent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(is_rd) && is_rd) |=> (viol_o && reason_o == 3'd1));

  p_wr_after_rd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(is_rd) && is_wr) |=> (viol_o && reason_o == 3'd6));
endmodule

// File: tb/ddr2_rd_timing_chk_tb.sv
module ddr2_rd_timing_chk_tb;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_DES = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic [2:0] bank_i = 3'd0;
  logic       a10_i = 1'b0;
  logic [3:0] al_i = 4'd0, cl_i = 4'd3, trtp_i = 4'd4;
  logic       bl8_i = 1'b1;
  logic       viol_o;
  logic [2:0] reason_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state, kept as clock stamps
  int now, g_t, g_bank;
  bit g_v, g_ap;
  bit [7:0] pw;
  int b_t[8];
  bit b_v[8], b_ap[8];
  int m_al, m_bl8, m_trtp;

  always #2 clk_i = ~clk_i;

  ddr2_rd_timing_chk u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .bank_i(bank_i), .a10_i(a10_i),
    .al_i(al_i), .cl_i(cl_i), .bl8_i(bl8_i), .trtp_i(trtp_i),
    .viol_o(viol_o), .reason_o(reason_o)
  );

  function automatic int pick(int best, int c);
    return (best == 0 || c < best) ? c : best;
  endfunction

  function automatic int model_code(int c, int bk, bit a10);
    int d = now - g_t;
    int half = m_bl8 ? 4 : 2;
    int lim = (m_al + half > m_al + m_trtp + (m_bl8 ? 2 : 0)) ?
              m_al + half : m_al + m_trtp + (m_bl8 ? 2 : 0);
    int best = 0;
    if (c == C_RD && g_v && d < half) begin
      if (d != 2) best = pick(best, 1);
      else if (g_ap) best = pick(best, 2);
      else if (pw[bk]) best = pick(best, 3);
    end
    if (c == C_PRE) begin
      for (int b = 0; b < 8; b++) begin
        if (a10 || b == bk) begin
          if (g_v && d == 1 && m_bl8 == 1 && !g_ap && b == g_bank) best = pick(best, 3);
          if (b_v[b]) begin
            if (b_ap[b]) best = pick(best, 5);
            else if (now - b_t[b] < lim) best = pick(best, 4);
          end
        end
      end
    end
    if (c == C_WR && g_v && d < half + 2) best = pick(best, 6);
    return best;
  endfunction

  function automatic void model_step(int c, int bk, bit a10);
    int d = now - g_t;
    bit [7:0] npw = '0;
    if (c == C_PRE && g_v && d == 1 && m_bl8 == 1 && !g_ap) npw = a10 ? 8'hFF : 8'(1 << bk);
    if (c == C_RD) begin
      g_v = 1; g_t = now; g_ap = a10; g_bank = bk;
      b_v[bk] = 1; b_t[bk] = now; b_ap[bk] = a10;
    end
    if (c == C_ACT) b_v[bk] = 0;
    if (c == C_PRE) begin
      for (int b = 0; b < 8; b++) if (a10 || b == bk) b_v[b] = 0;
    end
    pw = npw;
    now++;
  endfunction

  function automatic string req_of(int code);
    case (code)
      1: return "R3";
      2: return "R5";
      3: return "R6";
      4: return "R7/R8";
      5: return "R9";
      6: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic check(bit ok, string req, int gv, int gr, int ev, int er);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got viol=%0d reason=%0d expected viol=%0d reason=%0d",
               req, gv, gr, ev, er);
    end
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic do_cmd(int c, int bk, bit a10, string req);
    int e = model_code(c, bk, a10);
    cmd_i = 3'(c); bank_i = 3'(bk); a10_i = a10;
    @(posedge clk_i);
    model_step(c, bk, a10);
    @(negedge clk_i);
    check(viol_o == (e != 0) && reason_o == 3'(e), req, viol_o, reason_o, e != 0, e);
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) do_cmd(C_NOP, 0, 0, "R2");
  endtask

  task automatic apply_cfg(int al, int cl, int bl8, int trtp);
    @(negedge clk_i);
    rst_ni = 0; cmd_i = 3'd0;
    al_i = 4'(al); cl_i = 4'(cl); bl8_i = bl8[0]; trtp_i = 4'(trtp);
    m_al = al; m_bl8 = bl8; m_trtp = trtp;
    now = 0; g_t = -100; g_v = 0; g_ap = 0; g_bank = 0; pw = '0;
    for (int b = 0; b < 8; b++) begin b_v[b] = 0; b_ap[b] = 0; b_t[b] = -100; end
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    check(viol_o == 0 && reason_o == 0, "R1 reset", viol_o, reason_o, 0, 0);
  endtask

  task automatic random_run(int n);
    for (int i = 0; i < n; i++) begin
      int r = $urandom % 10;
      int c = (r < 2) ? C_NOP : (r == 2) ? C_ACT : (r < 6) ? C_RD :
              (r == 6) ? C_WR : (r < 9) ? C_PRE : C_DES;
      int bk = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 2);
      bit a10 = ($urandom % 4 == 0);
      do_cmd(c, bk, a10, req_of(model_code(c, bk, a10)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // AL=0 CL=3 BL=8 tRTP=4: precharge bound 6, write gap 6
    apply_cfg(0, 3, 1, 4);
    do_cmd(C_PRE, 0, 0, "R1 pre after reset");
    do_cmd(C_ACT, 0, 0, "R2 act");
    do_cmd(C_RD, 0, 0, "R4 first read");
    do_cmd(C_DES, 0, 0, "R2 deselect");
    do_cmd(C_RD, 1, 1, "R4 legal interrupt other bank");
    do_cmd(C_PRE, 1, 0, "R9 pre after ap read");
    do_cmd(C_ACT, 1, 0, "R13 act");
    do_cmd(C_PRE, 1, 0, "R13 pre after act");
    nops(4);
    do_cmd(C_RD, 0, 0, "R3 read");
    do_cmd(C_RD, 0, 0, "R3 spacing 1");
    nops(4);
    do_cmd(C_RD, 2, 1, "R5 ap read");
    nops(1);
    do_cmd(C_RD, 2, 0, "R5 interrupt of ap read");
    nops(4);
    do_cmd(C_RD, 3, 0, "R6 read");
    do_cmd(C_PRE, 3, 0, "R6 R12 pre in gap");
    do_cmd(C_RD, 3, 0, "R6 read to gap-precharged bank");
    nops(4);
    do_cmd(C_RD, 4, 0, "R3 read");
    nops(2);
    do_cmd(C_RD, 4, 0, "R3 spacing 3");
    nops(4);
    do_cmd(C_RD, 5, 0, "R11 read");
    do_cmd(C_WR, 5, 0, "R11 write at 1");
    do_cmd(C_RD, 5, 0, "R11 read");
    nops(4);
    do_cmd(C_WR, 5, 0, "R11 write at 5");
    do_cmd(C_RD, 5, 0, "R11 read");
    nops(5);
    do_cmd(C_WR, 5, 0, "R11 write at 6");
    nops(6);
    do_cmd(C_RD, 6, 0, "R8 read");
    nops(4);
    do_cmd(C_PRE, 6, 0, "R8 pre at 5 trtp bound");
    do_cmd(C_ACT, 6, 0, "R8 act");
    do_cmd(C_RD, 6, 0, "R8 read");
    nops(5);
    do_cmd(C_PRE, 6, 0, "R8 pre at 6");
    nops(6);
    do_cmd(C_RD, 7, 0, "R10 read");
    nops(3);
    do_cmd(C_PRE, 0, 1, "R10 all-bank pre early");
    nops(6);
    do_cmd(C_RD, 2, 1, "R10 ap read");
    nops(8);
    do_cmd(C_PRE, 5, 1, "R10 all-bank pre hits ap bank");
    random_run(1500);

    // AL=1 CL=4 BL=8 tRTP=1: bound AL+BL/2=5
    apply_cfg(1, 4, 1, 1);
    do_cmd(C_RD, 0, 0, "R8 read");
    nops(3);
    do_cmd(C_PRE, 0, 0, "R8 pre at 4 burst bound");
    do_cmd(C_RD, 1, 0, "R8 read");
    nops(4);
    do_cmd(C_PRE, 1, 0, "R8 pre at 5");
    random_run(1000);

    // AL=2 CL=3 BL=4 tRTP=3: bound 5, write gap 4
    apply_cfg(2, 3, 0, 3);
    do_cmd(C_RD, 0, 0, "R3 read");
    nops(1);
    do_cmd(C_RD, 1, 0, "R3 back-to-back at BL/2");
    nops(4);
    do_cmd(C_RD, 2, 0, "R3 read");
    do_cmd(C_RD, 2, 0, "R3 bl4 spacing 1");
    nops(6);
    do_cmd(C_RD, 3, 0, "R7 read");
    nops(3);
    do_cmd(C_PRE, 3, 0, "R7 pre at 4");
    do_cmd(C_RD, 3, 0, "R7 read");
    nops(4);
    do_cmd(C_PRE, 3, 0, "R7 pre at 5");
    do_cmd(C_RD, 4, 0, "R11 read");
    nops(2);
    do_cmd(C_WR, 4, 0, "R11 bl4 write at 3");
    do_cmd(C_RD, 4, 0, "R11 read");
    nops(3);
    do_cmd(C_WR, 4, 0, "R11 bl4 write at 4");
    random_run(1500);

    cmd_i = 3'd0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule